// File: doc/BRIEF.md
# Clock Policy Mask Engine

The block decides, for each of a set of clocks, whether that clock should run under the power policy now in force. It keeps one mask word for each policy. Every clock owns the same bit position in all of the mask words, and that bit says whether the clock runs while that policy is active. An external power controller supplies the active policy number. The block drives a registered per-clock enable vector.

Software reaches the block through a simple register bus with address, write data, write strobe and read data. Before anything other than the access register can be written, a key value set by a parameter must be written to the access register at address 0. The mask words can be edited only while the policy engine is halted. Software halts the engine through the control register. It restarts the engine with a GO command, which counts only when it comes with one of two restart-mode bits.

Register layout: address 0 is the access register. Reads return the unlock state in bit 0. Address 1 is the control register. A write sets bit 0 to halt, bit 1 for GO, and bits 2 and 3 for the two restart modes. A read returns halted in bit 0 and the sticky error flag in bit 4. Addresses 4 to 7 hold the mask words for policies 0 to 3. Every other address reads as zero.

Top module: `clk_policy_mask`

## Requirements
- R1: After reset the block is locked (address 0 reads 0) and the engine runs (control bit 0 reads 0). The error flag is clear, every mask word reads all ones and `clk_en` is all ones.
- R2: A write of the key to address 0 sets the unlock state. A write of any other value to address 0 clears it. Address 0 always accepts writes.
- R3: While the block is locked, writes to the control register and to the mask words change nothing.
- R4: An unlocked write to address 1 with bit 0 set halts the engine, and control bit 0 reads 1 from the next cycle.
- R5: An unlocked write to address 1 with bit 0 clear, bit 1 set, and bit 2 or bit 3 set restarts the engine. If bit 1 is set but both bits 2 and 3 are clear, the engine stays halted.
- R6: An unlocked mask write while the engine is halted stores the word, and it reads back unchanged.
- R7: An unlocked mask write while the engine runs is dropped, and it sets the error flag (control bit 4). The flag stays set until reset.
- R8: `clk_en` takes the mask word of the active policy at the clock edge that ends an accepted GO write.
- R9: While the engine runs, `clk_en` follows a change of `act_pol` at the next clock edge. While the engine is halted and no GO is accepted, `clk_en` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| act_pol | input | POL_W | Number of the active policy |
| clk_en | output | NUM_CLK | Registered per-clock enable vector |

## Verification
Some properties are checked on every cycle. The key write always unlocks. A halt command always halts. A GO without a mode bit never restarts the engine. A mask write while the engine runs never alters the stored word and always raises the error flag. `clk_en` never moves while the engine is halted and no GO is accepted. Other behaviours only the bench scenarios can show: that locked writes are ignored across the whole register set, that stored words read back, and that `clk_en` picks the right word after a restart and while the policy number is swept. The bench shows these by comparing against its own model on every edge.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  // control word fields
  localparam int CTL_HALT  = 0;
  localparam int CTL_GO    = 1;
  localparam int CTL_MODEA = 2;
  localparam int CTL_MODEB = 3;
  localparam int STS_ERR   = 4;

  // GO counts only with a mode bit and without a halt request
  function automatic logic go_valid(input logic [31:0] w);
    return w[CTL_GO] & (w[CTL_MODEA] | w[CTL_MODEB]) & ~w[CTL_HALT];
  endfunction

  function automatic logic [31:0] status_word(input logic halted, input logic err);
    logic [31:0] s;
    s = '0;
    s[CTL_HALT] = halted;
    s[STS_ERR]  = err;
    return s;
  endfunction
endpackage

// File: rtl/cpm_unlock.sv
module cpm_unlock #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'hC10C_4EED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output logic              unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key_val == DATA_W'(KEY));
  end

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && key_val == DATA_W'(KEY) |=> unlocked);
  // R2
  bad_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && key_val != DATA_W'(KEY) |=> !unlocked);
endmodule

// File: rtl/cpm_engine.sv
module cpm_engine
  import cpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_word,
  output logic        halted,
  output logic        go_ok
);
  logic halt_req;
  assign halt_req = ctl_wr & ctl_word[CTL_HALT];
  assign go_ok    = ctl_wr & go_valid(ctl_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted <= 1'b0;
    else if (halt_req) halted <= 1'b1;
    else if (go_ok)    halted <= 1'b0;
  end

  // R4
  halt_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> halted);
  // R5
  go_nomode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && ctl_wr && ctl_word[CTL_GO] && !ctl_word[CTL_MODEA] && !ctl_word[CTL_MODEB]
    |=> halted);
  // R5
  go_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok |=> !halted);
endmodule

// File: rtl/cpm_mask_bank.sv
module cpm_mask_bank #(
  parameter int NUM_POL = 4,
  parameter int NUM_CLK = 32,
  localparam int POL_W  = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr,
  input  logic [POL_W-1:0]   mask_idx,
  input  logic [NUM_CLK-1:0] mask_val,
  input  logic               halted,
  input  logic               go_ok,
  input  logic [POL_W-1:0]   act_pol,
  output logic [NUM_CLK-1:0] rd_mask,
  output logic [NUM_CLK-1:0] clk_en,
  output logic               err
);
  logic [NUM_CLK-1:0] mask_q [NUM_POL];
  logic               blocked;
  logic               refresh;
  logic [NUM_CLK-1:0] sel_mask;

  assign blocked = mask_wr & ~halted;
  assign refresh = go_ok | ~halted;

  for (genvar g = 0; g < NUM_POL; g++) begin : g_pol
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[g] <= '1;
      else if (mask_wr && halted && int'(mask_idx) == g)
        mask_q[g] <= mask_val;
    end

    // R7
    run_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked && int'(mask_idx) == g |=> $stable(mask_q[g]));
  end

  always_comb begin
    rd_mask  = (int'(mask_idx) < NUM_POL) ? mask_q[mask_idx] : '0;
    sel_mask = (int'(act_pol)  < NUM_POL) ? mask_q[act_pol]  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en <= '1;
      err    <= 1'b0;
    end else begin
      if (refresh) clk_en <= sel_mask;
      if (blocked) err    <= 1'b1;
    end
  end

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> err);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R9
  hold_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !go_ok |=> $stable(clk_en));
endmodule

// File: rtl/clk_policy_mask.sv
module clk_policy_mask
  import cpm_pkg::*;
#(
  parameter int          NUM_POL   = 4,
  parameter int          NUM_CLK   = 32,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 3,
  parameter int          MASK_BASE = 4,
  parameter logic [31:0] KEY       = 32'hC10C_4EED,
  localparam int         POL_W     = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_wr,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [POL_W-1:0]   act_pol,
  output logic [NUM_CLK-1:0] clk_en
);
  logic               unlocked, halted, go_ok, err;
  logic               hit_key, hit_ctl, hit_mask;
  logic [ADDR_W-1:0]  mask_off;
  logic [POL_W-1:0]   mask_idx;
  logic [NUM_CLK-1:0] rd_mask;
  logic [31:0]        ctl_word;

  assign hit_key  = (bus_addr == ADDR_W'(0));
  assign hit_ctl  = (bus_addr == ADDR_W'(1));
  assign hit_mask = (int'(bus_addr) >= MASK_BASE) && (int'(bus_addr) < MASK_BASE + NUM_POL);
  assign mask_off = bus_addr - ADDR_W'(MASK_BASE);
  assign mask_idx = mask_off[POL_W-1:0];
  assign ctl_word = 32'(bus_wdata);

  cpm_unlock #(.DATA_W(DATA_W), .KEY(KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .key_wr(bus_wr & hit_key),
    .key_val(bus_wdata), .unlocked(unlocked));

  cpm_engine u_engine (
    .clk(clk), .rst_n(rst_n), .ctl_wr(bus_wr & hit_ctl & unlocked),
    .ctl_word(ctl_word), .halted(halted), .go_ok(go_ok));

  cpm_mask_bank #(.NUM_POL(NUM_POL), .NUM_CLK(NUM_CLK)) u_bank (
    .clk(clk), .rst_n(rst_n), .mask_wr(bus_wr & hit_mask & unlocked),
    .mask_idx(mask_idx), .mask_val(bus_wdata[NUM_CLK-1:0]),
    .halted(halted), .go_ok(go_ok), .act_pol(act_pol),
    .rd_mask(rd_mask), .clk_en(clk_en), .err(err));

  always_comb begin
    bus_rdata = '0;
    if (hit_key)       bus_rdata = DATA_W'(unlocked);
    else if (hit_ctl)  bus_rdata = DATA_W'(status_word(halted, err));
    else if (hit_mask) bus_rdata = DATA_W'(rd_mask);
  end

  // R3
  locked_ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && bus_wr && hit_ctl |=> $stable(halted));
  // R3
  locked_err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && !err |=> !err);
endmodule

// File: tb/sim_clk_policy_mask.sv
module sim_clk_policy_mask;
  localparam logic [31:0] KEY = 32'hC10C_4EED;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0]  act_pol = 0;
  logic [31:0] clk_en;

  clk_policy_mask u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .act_pol(act_pol), .clk_en(clk_en));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit m_unl = 0, m_halt = 0, m_err = 0;
  bit [31:0] m_mask [4] = '{default: 32'hFFFF_FFFF};
  bit [31:0] m_en = 32'hFFFF_FFFF;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] model_read(int a);
    if (a == 0) return {31'b0, m_unl};
    if (a == 1) return (32'(m_err) << 4) | 32'(m_halt);
    if (a >= 4 && a < 8) return m_mask[a-4];
    return 0;
  endfunction

  // one clock: present a bus op, advance the model, compare clk_en after the edge
  task automatic cyc(bit wr, int a, bit [31:0] d, string tag);
    bit go, halt;
    bit [31:0] nen;
    bus_wr = wr; bus_addr = 3'(a); bus_wdata = d;
    halt = wr && m_unl && a == 1 && d[0];
    go   = wr && m_unl && a == 1 && d[1] && (d[2] || d[3]) && !d[0];
    nen  = (go || !m_halt) ? m_mask[act_pol] : m_en;
    if (wr && m_unl && a >= 4 && a < 8) begin
      if (m_halt) m_mask[a-4] = d; else m_err = 1;
    end
    if (halt) m_halt = 1; else if (go) m_halt = 0;
    if (wr && a == 0) m_unl = (d == KEY);
    m_en = nen;
    @(posedge clk); #1;
    chk(tag, clk_en, m_en);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, string tag);
    bus_wr = 0; bus_addr = 3'(a); #1;
    chk(tag, bus_rdata, model_read(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", clk_en, 32'hFFFF_FFFF);
    rd(0, "R1 access"); rd(1, "R1 status"); rd(4, "R1 mask0"); rd(7, "R1 mask3");
    // R3 locked writes ignored
    cyc(1, 1, 32'h1, "R3 ctl locked");  rd(1, "R3 still running");
    cyc(1, 5, 32'h0, "R3 mask locked"); rd(5, "R3 mask1 unchanged");
    // R2 unlock behaviour
    cyc(1, 0, 32'h1234_5678, "R2 wrong key"); rd(0, "R2 stays locked");
    cyc(1, 0, KEY, "R2 key"); rd(0, "R2 unlocked");
    // R7 write while running
    cyc(1, 4, 32'h0000_00F0, "R7 run write"); rd(4, "R7 dropped"); rd(1, "R7 err set");
    // R4 halt
    cyc(1, 1, 32'h1, "R4 halt"); rd(1, "R4 halted");
    // R6 mask writes
    cyc(1, 4, 32'hDEAD_0001, "R6 w0"); cyc(1, 5, 32'h0F0F_0F0F, "R6 w1");
    cyc(1, 6, 32'h8000_0000, "R6 w2"); cyc(1, 7, 32'h0000_0000, "R6 w3");
    for (int i = 4; i < 8; i++) rd(i, "R6 readback");
    rd(2, "R6 unmapped reads zero");
    // R9 hold while halted
    act_pol = 2; cyc(0, 0, 0, "R9 hold halted");
    // R5 GO without mode
    cyc(1, 1, 32'h2, "R5 go no mode"); rd(1, "R5 still halted");
    // R8 GO with mode A
    cyc(1, 1, 32'h6, "R8 go modeA"); rd(1, "R5 running");
    chk("R8 en = mask2", clk_en, 32'h8000_0000);
    // R9 follow policy
    for (int p = 0; p < 4; p++) begin act_pol = 2'(p); cyc(0, 0, 0, "R9 follow"); end
    chk("R9 en = mask3", clk_en, 32'h0);
    // R7 error sticky, R5 restart with mode B
    cyc(1, 1, 32'h1, "R4 halt again");
    cyc(1, 7, 32'h5555_AAAA, "R6 w3 again");
    cyc(1, 1, 32'hA, "R8 go modeB");
    chk("R8 en = new mask3", clk_en, 32'h5555_AAAA); rd(1, "R7 err sticky");
    // R2 relock then R3
    cyc(1, 0, 32'h0, "R2 relock"); rd(0, "R2 locked");
    cyc(1, 1, 32'h1, "R3 halt ignored"); rd(1, "R3 running");
    act_pol = 1; cyc(0, 0, 0, "R9 follow after relock");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule